// File: doc/BRIEF.md
# Lane-Width Partition Select Register

This block holds the configuration that decides how two clusters of serial I/O ports share their lanes. Cluster A has four ports. Cluster B has two configurable ports and one extra port that always runs at x4.

At each hard reset the block loads an active configuration for both clusters. The source is either a 4-bit external strap input or the next-configuration fields that software has programmed through a single register read/write port. A status bit records which source supplied the active configuration. The active configuration is decoded into a 2-bit width per port, which downstream link training uses. Encoding 111 selects auto negotiation and raises a flag for that cluster. A reserved encoding falls back to the all-x4 split and raises an error flag.

The programmed fields are sticky. Only the power-good (cold) reset clears them, so they survive the hard reset that applies them. Software programs the next split, issues a hard reset, and then reads back the configuration in use.

Top module: `lane_split_ctl`

## Requirements
- R1: While power-good reset (`pwrgood_n`) is low, `reg_rdata` reads 0, every port width reads x4 (1), and `cfg_err`, `auto_a` and `auto_b` read 0.
- R2: If the override bit is 0 when a hard reset loads the configuration, the active code for cluster A is `{1'b0, strap_i[3:2]}` and the code for cluster B is `{1'b0, strap_i[1:0]}`. The mode status bit then reads 0.
- R3: If the override bit is 1 when a hard reset loads the configuration, the next-configuration fields supply the active codes, the straps have no effect, and the mode status bit reads 1.
- R4: The block loads the active configuration only on clock edges where `hard_rst_n` is low. Writes and strap changes at other times leave the current fields, the mode bit, the port widths and the flags unchanged.
- R5: The override bit and both next-configuration fields keep their values through a hard reset. Only `pwrgood_n` low clears them to 0.
- R6: Register layout: [2:0] next code A, [5:3] next code B, [6] override enable, [9:7] current code A, [12:10] current code B, [13] mode. Writes change only bits [6:0]; bits [13:7] ignore written data.
- R7: Cluster A width codes, listed for ports A0 to A3:
  - 000 gives x4,x4,x4,x4.
  - 001 gives x8,off,x4,x4.
  - 010 gives x4,x4,x8,off.
  - 011 gives x8,off,x8,off.
  - 100 gives x16,off,off,off.
  - Port widths are encoded as 0 off, 1 x4, 2 x8, 3 x16.
- R8: Cluster B width codes, listed for ports B0 and B1: 000 gives x4,x4 and 010 gives x8,off. The fixed port always reads x4. `port_width` packs the ports as {A3,A2,A1,A0,B1,B0,fixed}, with the fixed port in bits [1:0].
- R9: An active code of 111 raises that cluster's auto flag (`auto_a` or `auto_b`) and drives all of that cluster's port widths to 0.
- R10: When a reserved code is selected, the block stores 000 as the current code for that cluster and that cluster's ports read x4. `cfg_err` is set at that hard reset and stays set until the next one. For cluster A the reserved codes are 101 and 110. For cluster B they are 001, 011, 100, 101 and 110.
- R11: Writes made while `hard_rst_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrgood_n | input | 1 | Cold reset, active low, asynchronous; clears all storage |
| hard_rst_n | input | 1 | Hard reset, active low; loads the active configuration |
| strap_i | input | 4 | External width straps: [3:2] cluster A, [1:0] cluster B |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 14 | Register read data |
| port_width | output | 14 | Per-port width, 2 bits per port |
| auto_a | output | 1 | Cluster A is set to auto negotiation |
| auto_b | output | 1 | Cluster B is set to auto negotiation |
| cfg_err | output | 1 | A reserved code was selected at the last hard reset |

## Verification
The assertions assume that `hard_rst_n` is held low while `pwrgood_n` is low, so that a cold reset also restarts the load. They also assume that the straps and the write port change only away from the rising clock edge. The stimulus raises power-good with the hard reset still low, and it drives straps and writes only right after a falling edge. It holds each hard reset for several cycles, which matches the repeated-load behaviour the properties describe.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   localparam int CFG_W = 3;
   localparam int WID_W = 2;

   localparam logic [WID_W-1:0] LW_OFF = 2'd0;
   localparam logic [WID_W-1:0] LW_X4  = 2'd1;
   localparam logic [WID_W-1:0] LW_X8  = 2'd2;
   localparam logic [WID_W-1:0] LW_X16 = 2'd3;

   localparam logic [CFG_W-1:0] CODE_ALLX4 = 3'b000;
   localparam logic [CFG_W-1:0] CODE_8_44  = 3'b001;
   localparam logic [CFG_W-1:0] CODE_44_8  = 3'b010;
   localparam logic [CFG_W-1:0] CODE_8_8   = 3'b011;
   localparam logic [CFG_W-1:0] CODE_16    = 3'b100;
   localparam logic [CFG_W-1:0] CODE_AUTO  = 3'b111;

   // register layout
   localparam int NXA_LSB  = 0;
   localparam int NXB_LSB  = NXA_LSB + CFG_W;
   localparam int OVR_BIT  = NXB_LSB + CFG_W;
   localparam int CUA_LSB  = OVR_BIT + 1;
   localparam int CUB_LSB  = CUA_LSB + CFG_W;
   localparam int MODE_BIT = CUB_LSB + CFG_W;
   localparam int REG_W    = MODE_BIT + 1;
endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
   import lsc_pkg::*;
#(
   parameter int NPORT = 4
) (
   input  logic [CFG_W-1:0]       code_i,
   output logic [NPORT*WID_W-1:0] width_o,
   output logic                   auto_o,
   output logic                   bad_o
);
   generate
      if (NPORT == 4) begin : g_quad
         always_comb begin
            auto_o = 1'b0;
            bad_o  = 1'b0;
            unique case (code_i)
               CODE_ALLX4: width_o = {LW_X4,  LW_X4,  LW_X4,  LW_X4};
               CODE_8_44:  width_o = {LW_X4,  LW_X4,  LW_OFF, LW_X8};
               CODE_44_8:  width_o = {LW_OFF, LW_X8,  LW_X4,  LW_X4};
               CODE_8_8:   width_o = {LW_OFF, LW_X8,  LW_OFF, LW_X8};
               CODE_16:    width_o = {LW_OFF, LW_OFF, LW_OFF, LW_X16};
               CODE_AUTO: begin
                  width_o = '0;
                  auto_o  = 1'b1;
               end
               default: begin
                  width_o = {LW_X4, LW_X4, LW_X4, LW_X4};
                  bad_o   = 1'b1;
               end
            endcase
         end
      end else if (NPORT == 2) begin : g_pair
         always_comb begin
            auto_o = 1'b0;
            bad_o  = 1'b0;
            unique case (code_i)
               CODE_ALLX4: width_o = {LW_X4,  LW_X4};
               CODE_44_8:  width_o = {LW_OFF, LW_X8};
               CODE_AUTO: begin
                  width_o = '0;
                  auto_o  = 1'b1;
               end
               default: begin
                  width_o = {LW_X4, LW_X4};
                  bad_o   = 1'b1;
               end
            endcase
         end
      end else begin : g_unsupported
         $error("lsc_decode: NPORT must be 2 or 4");
      end
   endgenerate
endmodule

// File: rtl/lsc_sticky.sv
module lsc_sticky
   import lsc_pkg::*;
(
   input  logic             clk,
   input  logic             pwrgood_n,
   input  logic             hard_rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic             ovr_en,
   output logic [CFG_W-1:0] nxt_a,
   output logic [CFG_W-1:0] nxt_b
);
   // read-only bits of the write word are dropped on purpose
   logic unused_ro;
   assign unused_ro = ^wdata[REG_W-1:CUA_LSB];

   always_ff @(posedge clk or negedge pwrgood_n) begin
      if (!pwrgood_n) begin
         ovr_en <= 1'b0;
         nxt_a  <= '0;
         nxt_b  <= '0;
      end else if (wr_en && hard_rst_n) begin
         ovr_en <= wdata[OVR_BIT];
         nxt_a  <= wdata[NXA_LSB +: CFG_W];
         nxt_b  <= wdata[NXB_LSB +: CFG_W];
      end
   end
endmodule

// File: rtl/lsc_capture.sv
module lsc_capture
   import lsc_pkg::*;
#(
   parameter int STRAP_W = 4,
   parameter int NPORT_A = 4,
   parameter int NPORT_B = 2
) (
   input  logic                     clk,
   input  logic                     pwrgood_n,
   input  logic                     hard_rst_n,
   input  logic [STRAP_W-1:0]       strap_i,
   input  logic                     ovr_en,
   input  logic [CFG_W-1:0]         nxt_a,
   input  logic [CFG_W-1:0]         nxt_b,
   output logic [CFG_W-1:0]         cur_a,
   output logic [CFG_W-1:0]         cur_b,
   output logic                     mode,
   output logic                     err,
   output logic [NPORT_A*WID_W-1:0] wid_a,
   output logic [NPORT_B*WID_W-1:0] wid_b,
   output logic                     auto_a,
   output logic                     auto_b
);
   localparam int SW = STRAP_W / 2;

   logic [CFG_W-1:0]         sel_a, sel_b;
   logic [NPORT_A*WID_W-1:0] dw_a;
   logic [NPORT_B*WID_W-1:0] dw_b;
   logic                     da_auto, db_auto, da_bad, db_bad;

   assign sel_a = ovr_en ? nxt_a : {{(CFG_W-SW){1'b0}}, strap_i[2*SW-1:SW]};
   assign sel_b = ovr_en ? nxt_b : {{(CFG_W-SW){1'b0}}, strap_i[SW-1:0]};

   lsc_decode #(.NPORT(NPORT_A)) u_dec_a (
      .code_i(sel_a), .width_o(dw_a), .auto_o(da_auto), .bad_o(da_bad));
   lsc_decode #(.NPORT(NPORT_B)) u_dec_b (
      .code_i(sel_b), .width_o(dw_b), .auto_o(db_auto), .bad_o(db_bad));

   always_ff @(posedge clk or negedge pwrgood_n) begin
      if (!pwrgood_n) begin
         cur_a  <= '0;
         cur_b  <= '0;
         mode   <= 1'b0;
         err    <= 1'b0;
         wid_a  <= {NPORT_A{LW_X4}};
         wid_b  <= {NPORT_B{LW_X4}};
         auto_a <= 1'b0;
         auto_b <= 1'b0;
      end else if (!hard_rst_n) begin
         cur_a  <= da_bad ? CODE_ALLX4 : sel_a;
         cur_b  <= db_bad ? CODE_ALLX4 : sel_b;
         mode   <= ovr_en;
         err    <= da_bad | db_bad;
         wid_a  <= dw_a;
         wid_b  <= dw_b;
         auto_a <= da_auto;
         auto_b <= db_auto;
      end
   end
endmodule

// File: rtl/lane_split_ctl.sv
module lane_split_ctl
   import lsc_pkg::*;
#(
   parameter int STRAP_W = 4,
   parameter int NPORT_A = 4,
   parameter int NPORT_B = 2,
   localparam int NPORT_T = NPORT_A + NPORT_B + 1,
   localparam int PW_W    = NPORT_T * WID_W
) (
   input  logic               clk,
   input  logic               pwrgood_n,
   input  logic               hard_rst_n,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               reg_wr_en,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic [PW_W-1:0]    port_width,
   output logic               auto_a,
   output logic               auto_b,
   output logic               cfg_err
);
   generate
      if (STRAP_W % 2 != 0 || STRAP_W / 2 > CFG_W) begin : g_bad_strap
         $error("lane_split_ctl: STRAP_W must be even and at most 2*CFG_W");
      end
      if (NPORT_A != 4 || NPORT_B != 2) begin : g_bad_ports
         $error("lane_split_ctl: cluster sizes must be 4 and 2");
      end
   endgenerate

   logic                     ovr_en, mode;
   logic [CFG_W-1:0]         nxt_a, nxt_b, cur_a, cur_b;
   logic [NPORT_A*WID_W-1:0] wid_a;
   logic [NPORT_B*WID_W-1:0] wid_b;

   lsc_sticky u_sticky (
      .clk(clk), .pwrgood_n(pwrgood_n), .hard_rst_n(hard_rst_n),
      .wr_en(reg_wr_en), .wdata(reg_wdata),
      .ovr_en(ovr_en), .nxt_a(nxt_a), .nxt_b(nxt_b));

   lsc_capture #(.STRAP_W(STRAP_W), .NPORT_A(NPORT_A), .NPORT_B(NPORT_B)) u_cap (
      .clk(clk), .pwrgood_n(pwrgood_n), .hard_rst_n(hard_rst_n),
      .strap_i(strap_i), .ovr_en(ovr_en), .nxt_a(nxt_a), .nxt_b(nxt_b),
      .cur_a(cur_a), .cur_b(cur_b), .mode(mode), .err(cfg_err),
      .wid_a(wid_a), .wid_b(wid_b), .auto_a(auto_a), .auto_b(auto_b));

   assign reg_rdata  = {mode, cur_b, cur_a, ovr_en, nxt_b, nxt_a};
   assign port_width = {wid_a, wid_b, LW_X4};
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
   import lsc_pkg::*;
(
   input logic             clk,
   input logic             pwrgood_n,
   input logic             hard_rst_n,
   input logic [REG_W-1:0] reg_rdata,
   input logic [13:0]      port_width,
   input logic             auto_a,
   input logic             auto_b,
   input logic             cfg_err
);
   logic [CFG_W-1:0] ca, cb;
   assign ca = reg_rdata[CUA_LSB +: CFG_W];
   assign cb = reg_rdata[CUB_LSB +: CFG_W];

   AST_STICKY_HOLD_IN_HRST: assert property (@(posedge clk) disable iff (!pwrgood_n)
      !hard_rst_n |=> $stable(reg_rdata[OVR_BIT:0])); // R11

   AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!pwrgood_n)
      (hard_rst_n && $past(hard_rst_n)) |->
         ($stable(reg_rdata[REG_W-1:CUA_LSB]) && $stable(port_width) && $stable(cfg_err))); // R4

   AST_MODE_TRACKS_OVR: assert property (@(posedge clk) disable iff (!pwrgood_n)
      !hard_rst_n |=> (reg_rdata[MODE_BIT] == $past(reg_rdata[OVR_BIT]))); // R3

   AST_FIXED_PORT_X4: assert property (@(posedge clk) disable iff (!pwrgood_n)
      port_width[1:0] == LW_X4); // R8

   AST_AUTO_A_OFF: assert property (@(posedge clk) disable iff (!pwrgood_n)
      auto_a |-> (port_width[13:6] == '0 && ca == CODE_AUTO)); // R9

   AST_AUTO_B_OFF: assert property (@(posedge clk) disable iff (!pwrgood_n)
      auto_b |-> (port_width[5:2] == '0 && cb == CODE_AUTO)); // R9

   AST_NO_RESERVED_STORED: assert property (@(posedge clk) disable iff (!pwrgood_n)
      (ca != 3'b101 && ca != 3'b110 &&
       (cb == CODE_ALLX4 || cb == CODE_44_8 || cb == CODE_AUTO))); // R10

   AST_ERR_ONLY_AT_HRST: assert property (@(posedge clk) disable iff (!pwrgood_n)
      $rose(cfg_err) |-> $past(!hard_rst_n)); // R10
endmodule

bind lane_split_ctl lsc_checker u_chk (
   .clk(clk), .pwrgood_n(pwrgood_n), .hard_rst_n(hard_rst_n),
   .reg_rdata(reg_rdata), .port_width(port_width),
   .auto_a(auto_a), .auto_b(auto_b), .cfg_err(cfg_err));

// File: tb/sim_lane_split_ctl.sv
module sim_lane_split_ctl;
   logic        clk = 1'b0;
   logic        pwrgood_n = 1'b0;
   logic        hard_rst_n = 1'b0;
   logic [3:0]  strap_i = 4'b0;
   logic        reg_wr_en = 1'b0;
   logic [13:0] reg_wdata = '0;
   logic [13:0] reg_rdata;
   logic [13:0] port_width;
   logic        auto_a, auto_b, cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lane_split_ctl u0 (
      .clk(clk), .pwrgood_n(pwrgood_n), .hard_rst_n(hard_rst_n),
      .strap_i(strap_i), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .port_width(port_width),
      .auto_a(auto_a), .auto_b(auto_b), .cfg_err(cfg_err));

   localparam logic [13:0] ALL4 = 14'b01010101010101;

   // {ovr, nxt_a, nxt_b, strap, exp_a, exp_b, mode, err, auto_a, auto_b, widths}
   localparam int NV = 9;
   localparam logic [34:0] VEC [NV] = '{
      {1'b0, 3'd0, 3'd0, 4'b0000, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, ALL4},
      {1'b0, 3'd4, 3'd2, 4'b0110, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 14'b01010010001001},
      {1'b0, 3'd7, 3'd7, 4'b1001, 3'd2, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 14'b00100101010101},
      {1'b0, 3'd0, 3'd0, 4'b1111, 3'd3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 14'b00100010010101},
      {1'b1, 3'd4, 3'd2, 4'b0101, 3'd4, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 14'b00000011001001},
      {1'b1, 3'd7, 3'd7, 4'b0000, 3'd7, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 14'b00000000000001},
      {1'b1, 3'd5, 3'd0, 4'b1111, 3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, ALL4},
      {1'b1, 3'd3, 3'd4, 4'b0110, 3'd3, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 14'b00100010010101},
      {1'b1, 3'd6, 3'd0, 4'b1010, 3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, ALL4}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [13:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic hard_pulse();
      @(negedge clk);
      hard_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      hard_rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      // R1: cold reset state
      repeat (3) @(negedge clk);
      chk("R1 rdata", {2'b0, reg_rdata}, 16'h0);
      chk("R1 widths", {2'b0, port_width}, {2'b0, ALL4});
      chk("R1 flags", {13'b0, cfg_err, auto_a, auto_b}, 16'h0);
      pwrgood_n = 1'b1;
      repeat (2) @(negedge clk);
      hard_rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [34:0] v;
         logic [13:0] exp_rd;
         v = VEC[i];
         wr({7'b0, v[34], v[30:28], v[33:31]});
         strap_i = v[27:24];
         hard_pulse();
         exp_rd = {v[17], v[20:18], v[23:21], v[34], v[30:28], v[33:31]};
         chk(v[34] ? "R3 rdata" : "R2 rdata", {2'b0, reg_rdata}, {2'b0, exp_rd});
         chk("R5 sticky kept", {9'b0, reg_rdata[6:0]}, {9'b0, exp_rd[6:0]});
         chk("R7 R8 widths", {2'b0, port_width}, {2'b0, v[13:0]});
         chk("R8 fixed port", {14'b0, port_width[1:0]}, 16'd1);
         chk("R10 err", {15'b0, cfg_err}, {15'b0, v[16]});
         chk("R9 auto", {14'b0, auto_a, auto_b}, {14'b0, v[15:14]});
      end

      // R4: no change outside hard reset (state: cur 0/0, mode 1, err 1)
      wr({7'b0, 1'b0, 3'd2, 3'd3});
      strap_i = 4'b0110;
      repeat (2) @(negedge clk);
      chk("R4 status held", {9'b0, reg_rdata[13:7]}, {9'b0, 1'b1, 3'd0, 3'd0});
      chk("R4 widths held", {2'b0, port_width}, {2'b0, ALL4});
      chk("R4 err held", {15'b0, cfg_err}, 16'd1);
      hard_pulse();
      chk("R2 reload from straps", {2'b0, reg_rdata}, {2'b0, 1'b0, 3'd2, 3'd1, 1'b0, 3'd2, 3'd3});
      chk("R2 widths", {2'b0, port_width}, {2'b0, 14'b01010010001001});

      // R6: read-only bits ignore writes
      wr({7'b1111111, 1'b0, 3'd0, 3'd0});
      @(negedge clk);
      chk("R6 ro ignored", {2'b0, reg_rdata}, {2'b0, 1'b0, 3'd2, 3'd1, 7'b0});

      // R11: writes during hard reset ignored
      @(negedge clk);
      hard_rst_n = 1'b0;
      wr({7'b0, 1'b1, 3'd2, 3'd4});
      @(negedge clk);
      hard_rst_n = 1'b1;
      @(negedge clk);
      chk("R11 write in hrst", {2'b0, reg_rdata}, {2'b0, 1'b0, 3'd2, 3'd1, 7'b0});

      // R5: cold reset clears sticky fields
      wr({7'b0, 1'b1, 3'd2, 3'd4});
      chk("R5 written", {9'b0, reg_rdata[6:0]}, {9'b0, 1'b1, 3'd2, 3'd4});
      @(negedge clk);
      hard_rst_n = 1'b0;
      pwrgood_n  = 1'b0;
      repeat (2) @(negedge clk);
      chk("R5 cold clear", {2'b0, reg_rdata}, 16'h0);
      chk("R1 widths after cold", {2'b0, port_width}, {2'b0, ALL4});
      pwrgood_n = 1'b1;
      @(negedge clk);
      hard_rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      report();
   end
endmodule